// File: doc/BRIEF.md
# Dual-Edge I/Q Codec Byte Interleaver

This block joins an 8-bit parallel host byte path to a pair of I/Q data converters. Everything runs on one fabric clock at twice the converter sample rate. A phase input tells the block which half of the converter clock the current fabric cycle falls in. In receive mode the block takes the ADC's Q sample in the low half and its I sample in the high half. It registers each sample for one fabric cycle and then places it on the host byte output, so Q and I bytes alternate. In transmit mode the host supplies alternating Q and I bytes. The block registers each byte once and then presents it, left-aligned and zero-padded, on a 10-bit DAC word.

A qualifier output tells the host which bytes count. It rises only on a Q byte, so every qualified stream starts Q first. It drops whenever the stream is disabled, capture is turned off, or the direction is changing. A change of direction flushes the byte pipeline and holds the qualifier low for two converter clock periods. The host byte output is enabled only in receive mode.

Top module: `iq_byte_interleaver`

## Requirements
- R1: A synchronous reset leaves `qual`, `byte_is_q` and `host_oe` at 0 and leaves `host_dout` and `dac_word` at all zeros after the reset edge. The first edge after reset with `dir_tx` = 0 counts as a direction change (see R9).
- R2: In receive mode (`dir_tx` = 0), the byte sampled at edge E is `adc_q` when `cnv_hi` = 0 and `adc_i` when `cnv_hi` = 1. While `qual` = 1, that byte appears on `host_dout` after edge E+1.
- R3: `byte_is_q` = 1 marks the qualified byte as a Q sample and 0 marks it as an I sample. `qual` only rises in a cycle where `byte_is_q` = 1.
- R4: While `qual` stays 1 on consecutive cycles, `byte_is_q` alternates every cycle.
- R5: In transmit mode (`dir_tx` = 1), the `host_din` byte sampled at edge E appears on `dac_word[9:2]` after edge E+1 while `qual` = 1. A byte sampled with `cnv_hi` = 0 is a Q byte.
- R6: `dac_word[1:0]` is always 0.
- R7: If `stream_dis` = 1 or `cap_en` = 0 at an edge, `qual` is 0 after that edge.
- R8: Whenever `qual` = 0, `host_dout` and `dac_word` are all zeros.
- R9: After every edge, `host_oe` equals the inverse of the `dir_tx` value sampled at that edge. In transmit mode `host_dout` is all zeros.
- R10: When `dir_tx` sampled at edge E differs from its value at the previous edge, `qual` stays 0 after edges E through E+4. That is two converter periods plus the edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, twice the converter rate |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 1 = transmit to DAC, 0 = receive from ADC |
| stream_dis | input | 1 | 1 stops the data stream |
| cap_en | input | 1 | 1 allows bytes to be qualified |
| cnv_hi | input | 1 | 1 while the converter clock is in its high half |
| adc_i | input | 8 | ADC I channel sample |
| adc_q | input | 8 | ADC Q channel sample |
| host_din | input | 8 | Host byte for the DAC (transmit) |
| host_dout | output | 8 | Byte to the host (receive) |
| host_oe | output | 1 | Output enable for the host byte bus |
| qual | output | 1 | Byte on the bus/DAC is valid |
| byte_is_q | output | 1 | Current qualified byte is Q (1) or I (0) |
| dac_word | output | 10 | DAC word, host byte in bits 9..2 |

## Verification
Each data byte takes two registers, so a sample taken at edge E is checked just after edge E+1. The qualifier, the channel flag and the output enable come from the controls sampled at that same edge and are checked after it. The bench models the capture and output registers from the requirements, steps that model once per posedge using the inputs held since the previous cycle, and compares all ports 2 ns after the edge. After each direction change, an explicit loop confirms that the qualifier stays low for the five edges of the flush window.

// File: rtl/iqil_pkg.sv
package iqil_pkg;
  typedef enum logic {
    CH_I = 1'b0,
    CH_Q = 1'b1
  } iq_chan_e;

  function automatic iq_chan_e chan_of_phase(input logic hi_half);
    return hi_half ? CH_I : CH_Q;
  endfunction
endpackage

// File: rtl/iqil_dir_guard.sv
module iqil_dir_guard #(
  parameter int FLUSH_CNV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dir_tx,
  output logic dir_q,
  output logic flushing,
  output logic oe
);
  localparam int FLUSH_LEN = 2 * FLUSH_CNV;
  localparam int CW = $clog2(FLUSH_LEN + 1);

  logic [CW-1:0] left_q;
  logic          swap;

  assign swap     = (dir_tx != dir_q);
  assign flushing = swap || (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b1;
      left_q <= '0;
      oe     <= 1'b0;
    end else begin
      dir_q <= dir_tx;
      oe    <= ~dir_tx;
      if (swap)
        left_q <= CW'(FLUSH_LEN);
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/iqil_capture.sv
module iqil_capture
  import iqil_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flushing,
  input  logic          dir_tx,
  input  logic          cnv_hi,
  input  logic [BW-1:0] adc_i,
  input  logic [BW-1:0] adc_q,
  input  logic [BW-1:0] host_din,
  output logic [BW-1:0] stage_data,
  output iq_chan_e      stage_chan
);
  logic [BW-1:0] pick;

  always_comb begin
    if (dir_tx)
      pick = host_din;
    else if (chan_of_phase(cnv_hi) == CH_Q)
      pick = adc_q;
    else
      pick = adc_i;
  end

  always_ff @(posedge clk) begin
    if (rst || flushing) begin
      stage_data <= '0;
      stage_chan <= CH_I;
    end else begin
      stage_data <= pick;
      stage_chan <= chan_of_phase(cnv_hi);
    end
  end
endmodule

// File: rtl/iqil_emit.sv
module iqil_emit
  import iqil_pkg::*;
#(
  parameter int BW = 8,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          dir_q,
  input  logic [BW-1:0] stage_data,
  input  iq_chan_e      stage_chan,
  output logic [BW-1:0] host_dout,
  output logic          qual,
  output logic          byte_is_q,
  output logic [DW-1:0] dac_word
);
  logic          run_q;
  logic          run_d;
  logic [DW-1:0] dac_next;

  generate
    if (DW > BW) begin : g_pad
      assign dac_next = {stage_data, {(DW-BW){1'b0}}};
    end else begin : g_trim
      assign dac_next = stage_data[BW-1 -: DW];
    end
  endgenerate

  assign run_d = go && (run_q || (stage_chan == CH_Q));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      qual      <= 1'b0;
      byte_is_q <= 1'b0;
      host_dout <= '0;
      dac_word  <= '0;
    end else begin
      run_q     <= run_d;
      qual      <= run_d;
      byte_is_q <= run_d && (stage_chan == CH_Q);
      host_dout <= (run_d && !dir_q) ? stage_data : '0;
      dac_word  <= (run_d && dir_q) ? dac_next : '0;
    end
  end
endmodule

// File: rtl/iq_byte_interleaver.sv
module iq_byte_interleaver
  import iqil_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int DAC_W     = 10,
  parameter int FLUSH_CNV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_tx,
  input  logic             stream_dis,
  input  logic             cap_en,
  input  logic             cnv_hi,
  input  logic [BUS_W-1:0] adc_i,
  input  logic [BUS_W-1:0] adc_q,
  input  logic [BUS_W-1:0] host_din,
  output logic [BUS_W-1:0] host_dout,
  output logic             host_oe,
  output logic             qual,
  output logic             byte_is_q,
  output logic [DAC_W-1:0] dac_word
);
  logic             dir_q;
  logic             flushing;
  logic             go;
  logic [BUS_W-1:0] stage_data;
  iq_chan_e         stage_chan;

  iqil_dir_guard #(.FLUSH_CNV(FLUSH_CNV)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .dir_tx   (dir_tx),
    .dir_q    (dir_q),
    .flushing (flushing),
    .oe       (host_oe)
  );

  iqil_capture #(.BW(BUS_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .flushing   (flushing),
    .dir_tx     (dir_tx),
    .cnv_hi     (cnv_hi),
    .adc_i      (adc_i),
    .adc_q      (adc_q),
    .host_din   (host_din),
    .stage_data (stage_data),
    .stage_chan (stage_chan)
  );

  assign go = !stream_dis && cap_en && !flushing;

  iqil_emit #(.BW(BUS_W), .DW(DAC_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .dir_q      (dir_q),
    .stage_data (stage_data),
    .stage_chan (stage_chan),
    .host_dout  (host_dout),
    .qual       (qual),
    .byte_is_q  (byte_is_q),
    .dac_word   (dac_word)
  );
endmodule

// File: rtl/iqil_checker.sv
module iqil_checker #(
  parameter int BW = 8,
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_tx,
  input logic          stream_dis,
  input logic          cap_en,
  input logic [BW-1:0] host_dout,
  input logic          host_oe,
  input logic          qual,
  input logic          byte_is_q,
  input logic [DW-1:0] dac_word
);
  a_r3_q_first: assert property (@(posedge clk) disable iff (rst)
    $rose(qual) |-> byte_is_q);

  a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
    (qual && $past(qual)) |-> (byte_is_q != $past(byte_is_q)));

  a_r6_dac_pad: assert property (@(posedge clk) disable iff (rst)
    dac_word[1:0] == 2'b00);

  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    qual |-> $past(!stream_dis && cap_en));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !qual |-> (host_dout == '0 && dac_word == '0));

  a_r9_no_drive_tx: assert property (@(posedge clk) disable iff (rst)
    $past(dir_tx) |-> (!host_oe && host_dout == '0));

  a_r10_flush: assert property (@(posedge clk) disable iff (rst)
    ($past(dir_tx) != $past(dir_tx, 2)) |-> !qual);
endmodule

bind iq_byte_interleaver iqil_checker #(.BW(BUS_W), .DW(DAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dir_tx     (dir_tx),
  .stream_dis (stream_dis),
  .cap_en     (cap_en),
  .host_dout  (host_dout),
  .host_oe    (host_oe),
  .qual       (qual),
  .byte_is_q  (byte_is_q),
  .dac_word   (dac_word)
);

// File: tb/tb_iq_byte_interleaver.sv
`timescale 1ns/1ps
module tb_iq_byte_interleaver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_tx = 1'b1;
  logic       stream_dis = 1'b1;
  logic       cap_en = 1'b0;
  logic       cnv_hi = 1'b0;
  logic [7:0] adc_i = '0;
  logic [7:0] adc_q = '0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout;
  logic       host_oe;
  logic       qual;
  logic       byte_is_q;
  logic [9:0] dac_word;

  int total = 0;
  int fails = 0;

  // expected-value model, built from the requirements
  logic [7:0] m_byte = '0;
  logic       m_isq = 1'b0;
  logic       m_dir = 1'b1;
  int         m_left = 0;
  logic       m_run = 1'b0;
  logic       e_qual = 1'b0, e_isq = 1'b0, e_oe = 1'b0;
  logic [7:0] e_dout = '0;
  logic [9:0] e_dac = '0;

  always #5 clk = ~clk;

  iq_byte_interleaver dut (
    .clk(clk), .rst(rst), .dir_tx(dir_tx), .stream_dis(stream_dis),
    .cap_en(cap_en), .cnv_hi(cnv_hi), .adc_i(adc_i), .adc_q(adc_q),
    .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe),
    .qual(qual), .byte_is_q(byte_is_q), .dac_word(dac_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pick_byte();
    if (dir_tx) return host_din;
    return cnv_hi ? adc_i : adc_q;
  endfunction

  task automatic model_edge();
    logic chg, flush, go, run_n;
    if (rst) begin
      m_byte = '0; m_isq = 0; m_dir = 1; m_left = 0; m_run = 0;
      e_qual = 0; e_isq = 0; e_oe = 0; e_dout = '0; e_dac = '0;
      return;
    end
    chg   = (dir_tx != m_dir);
    flush = chg || (m_left != 0);
    go    = !stream_dis && cap_en && !flush;
    run_n = go && (m_run || m_isq);
    e_qual = run_n;
    e_isq  = run_n && m_isq;
    e_dout = (run_n && !m_dir) ? m_byte : 8'h00;
    e_dac  = (run_n && m_dir) ? {m_byte, 2'b00} : 10'h000;
    e_oe   = !dir_tx;
    m_byte = flush ? 8'h00 : pick_byte();
    m_isq  = flush ? 1'b0 : !cnv_hi;
    m_left = chg ? 4 : (m_left > 0 ? m_left - 1 : 0);
    m_dir  = dir_tx;
    m_run  = run_n;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
  endtask

  task automatic compare_all();
    chk("R2 R9 host_dout", {24'h0, host_dout}, {24'h0, e_dout});
    chk("R5 R6 dac_word", {22'h0, dac_word}, {22'h0, e_dac});
    chk("R3 R7 R8 qual", {31'h0, qual}, {31'h0, e_qual});
    chk("R3 R4 byte_is_q", {31'h0, byte_is_q}, {31'h0, e_isq});
    chk("R9 host_oe", {31'h0, host_oe}, {31'h0, e_oe});
  endtask

  task automatic drive_rand(input int off_pct);
    cnv_hi   = ~cnv_hi;
    adc_i    = 8'($urandom);
    adc_q    = 8'($urandom);
    host_din = 8'($urandom);
    stream_dis = (($urandom % 100) < off_pct);
    cap_en     = !(($urandom % 100) < off_pct);
  endtask

  task automatic run_cycles(input int n, input int off_pct, input int swap_pct);
    for (int k = 0; k < n; k++) begin
      drive_rand(off_pct);
      if (($urandom % 1000) < swap_pct) dir_tx = ~dir_tx;
      tick();
      compare_all();
    end
  endtask

  task automatic flip_dir_and_watch();
    dir_tx = ~dir_tx;
    for (int k = 0; k < 5; k++) begin
      cnv_hi = (k == 0) ? ~cnv_hi : cnv_hi;
      tick();
      chk("R10 flush window qual", {31'h0, qual}, 32'h0);
      compare_all();
      cnv_hi = ~cnv_hi;
    end
  endtask

  initial begin
    #1_900_000;
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R1 qual", {31'h0, qual}, 32'h0);
      chk("R1 host_oe", {31'h0, host_oe}, 32'h0);
      chk("R1 host_dout", {24'h0, host_dout}, 32'h0);
      chk("R1 dac_word", {22'h0, dac_word}, 32'h0);
      chk("R1 byte_is_q", {31'h0, byte_is_q}, 32'h0);
    end
    rst = 1'b0;
    stream_dis = 1'b0;
    cap_en = 1'b1;
    dir_tx = 1'b0;
    // first edge after reset in receive mode flushes (R10)
    for (int k = 0; k < 5; k++) begin
      cnv_hi = ~cnv_hi;
      tick();
      chk("R10 post-reset flush qual", {31'h0, qual}, 32'h0);
      compare_all();
    end
    // directed receive stream: Q first then alternation (R2 R3 R4)
    run_cycles(400, 0, 0);
    // receive with disable / capture gaps (R7 R8)
    run_cycles(600, 15, 0);
    // directed: disable held high
    stream_dis = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cnv_hi = ~cnv_hi;
      tick();
      chk("R7 disable qual", {31'h0, qual}, 32'h0);
      chk("R8 disable dout", {24'h0, host_dout}, 32'h0);
    end
    stream_dis = 1'b0;
    // switch to transmit (R9 R10), then DAC stream (R5 R6)
    flip_dir_and_watch();
    chk("R9 tx oe off", {31'h0, host_oe}, 32'h0);
    run_cycles(600, 0, 0);
    run_cycles(400, 10, 0);
    // back to receive
    flip_dir_and_watch();
    chk("R9 rx oe on", {31'h0, host_oe}, 32'h1);
    // random mix with direction swaps
    run_cycles(1500, 10, 8);
    // mid-run reset (R1)
    rst = 1'b1;
    tick();
    chk("R1 mid reset qual", {31'h0, qual}, 32'h0);
    chk("R1 mid reset oe", {31'h0, host_oe}, 32'h0);
    chk("R1 mid reset dac", {22'h0, dac_word}, 32'h0);
    rst = 1'b0;
    run_cycles(300, 5, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule